// File: doc/BRIEF.md
# Serial Transmitter with Break Sequencing

This block serialises bytes onto a single asynchronous line. Each byte gets a low start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit and one high stop bit. Bytes arrive over a valid/ready stream into a one-word holding register. From there they move into a shift register that puts out one bit per period of an external single-cycle baud tick.

Two command strobes produce a line break. A start-break strobe arms a break, which is launched as soon as the character in flight has finished. The break behaves like a pseudo-character: it takes over the transmit path, holds the line low for at least one full character time under the current framing, and stays low until a stop-break strobe has been seen. After the break the line returns high for a recovery gap of at least twelve bit periods, or for the programmed guard time if that is longer. Two status flags report whether the holding register can take data and whether the transmitter is completely idle.

Stream rules: `in_ready` equals `tx_rdy`. A word transfers on any clock where `in_valid` and `in_ready` are both high. The source may hold `in_valid` high for as long as it likes while `in_ready` is low. The word then waits with no loss. The one exception is R11.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, and whenever `tx_empty` is 1, `txd` is 1. Out of reset `tx_rdy`, `tx_empty` and `in_ready` are all 1.
- R2: A character is 0 for one bit period, then 5+`cfg_nbits` data bits LSB first (code 0..3 selects 5..8 bits), then a parity bit when `cfg_par_en`=1, then a 1 stop bit. Each bit lasts exactly one baud-tick interval. The parity bit is the XOR of the data bits when `cfg_par_odd`=0 (even) and its inverse when `cfg_par_odd`=1.
- R3: `in_ready` always equals `tx_rdy`. A transfer happens on a clock with `in_valid` and `in_ready` both high. The holding register takes one word while a character is being shifted.
- R4: A start-break accepted while a character is shifting lets that character finish, stop bit included. The line goes low in the bit period that directly follows the stop bit.
- R5: Once started, a break keeps `txd` low for at least the current frame length in bit periods (start + data + parity + stop). When stop-break came before that minimum ran out, the break lasts exactly that frame length.
- R6: With no stop-break, the break holds the line low for as long as needed. A stop-break arriving after the minimum ends the break at the next baud tick.
- R7: While a break is pending, active or in its recovery gap, further start-break strobes have no effect.
- R8: A stop-break strobe with no break pending or active is ignored and is not remembered.
- R9: When start-break and stop-break are strobed in the same cycle, the start is taken and that stop is ignored.
- R10: After a break, `txd` stays high for max(12, `cfg_guard`) bit periods before any new character can start.
- R11: A word transferred while a break is pending but not yet started completes its handshake and is discarded. It is never transmitted.
- R12: Start-break is accepted only while `tx_rdy` is 1. Stop-break is accepted while a break is pending or active. `tx_rdy` and `tx_empty` are 0 from the start of the break until the recovery gap ends, and both return to 1 after the gap when no data is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit-period boundary |
| cfg_nbits | input | 2 | Data length code, 5 + value bits |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_guard | input | 8 | Recovery gap length in bit periods when above 12 |
| in_valid | input | 1 | Source offers a data word |
| in_ready | output | 1 | Holding register can take a word |
| in_data | input | 8 | Data word, LSB sent first |
| brk_start | input | 1 | Start-break command strobe |
| brk_stop | input | 1 | Stop-break command strobe |
| txd | output | 1 | Serial line, idles high |
| tx_rdy | output | 1 | Holding register free and no break running |
| tx_empty | output | 1 | Nothing held, shifting, pending or breaking |

## Verification
The framing path is swept over every data value for each of the four lengths and all three parity settings, so each bit position, each parity choice and each frame length is told apart by the serial pattern it produces. The break path gets four command orderings: an early stop against an idle line, a start landing in the middle of a character with a data word pushed while the break is pending, a lone stop followed by a simultaneous start and stop and then a late stop, and a short frame with a long guard. Measuring the low run tells a break of minimum length apart from one ended by its stop, and shows whether a stray stop was wrongly latched. The high run that follows tells the 12-period floor apart from the guard value, and shows whether the discarded word or a repeated start leaked through.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
package utx_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SHIFT = 2'd1,
    S_BREAK = 2'd2,
    S_GAP   = 2'd3
  } utx_state_t;
endpackage

// File: rtl/utx_hold.sv
`timescale 1ns/1ps
// One-word holding register between the stream input and the shifter.
module utx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_en) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (pop) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/utx_framer.sv
`timescale 1ns/1ps
// Builds the bit image of one character (bit 0 goes out first) and its length.
module utx_framer #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [1:0]         nbits_code,
  input  logic               par_en,
  input  logic               par_odd,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   frame_len
);
  localparam int MIN_BITS = DATA_W - 3;

  always_comb begin
    int  nb;
    logic par;
    nb    = MIN_BITS + int'(nbits_code);
    par   = par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nb) begin
        frame[1 + i] = data[i];
        par          = par ^ data[i];
      end
    end
    if (par_en) frame[1 + nb] = par;
    frame_len = LEN_W'(nb + 2 + int'(par_en));
  end
endmodule

// File: rtl/utx_engine.sv
`timescale 1ns/1ps
// Bit sequencer: shifts characters, runs the break pseudo-character and recovery gap.
module utx_engine
  import utx_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int LEN_W   = 4,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               hold_full,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [CNT_W-1:0]   gap_len,
  input  logic               start_acc,
  input  logic               start_raw,
  input  logic               stop_raw,
  output logic               take,
  output logic               txd,
  output logic               brk_pend,
  output logic               brk_on,
  output logic               gap_on,
  output logic               idle,
  output logic [LEN_W-1:0]   len_q
);
  utx_state_t         st;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic               stop_req;

  logic [CNT_W:0] cnt_nx;
  logic           lim_frame, lim_gap, free, stop_acc, brk_exit;

  assign cnt_nx    = {1'b0, cnt} + 1'b1;
  assign lim_frame = cnt_nx >= {{(CNT_W + 1 - LEN_W){1'b0}}, len_q};
  assign lim_gap   = cnt_nx >= {1'b0, gap_len};
  assign free      = tick && ((st == S_IDLE) ||
                              (st == S_SHIFT && lim_frame) ||
                              (st == S_GAP && lim_gap));
  assign take      = free && !brk_pend && hold_full;
  assign brk_exit  = tick && (st == S_BREAK) && lim_frame && stop_req;
  assign stop_acc  = stop_raw && !start_raw && (brk_pend || st == S_BREAK);

  assign brk_on = (st == S_BREAK);
  assign gap_on = (st == S_GAP);
  assign idle   = (st == S_IDLE);

  always_comb begin
    case (st)
      S_SHIFT: txd = shreg[0];
      S_BREAK: txd = 1'b0;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      shreg    <= '1;
      len_q    <= '0;
      brk_pend <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      if (free) begin
        cnt <= '0;
        if (brk_pend) begin
          st       <= S_BREAK;
          len_q    <= frame_len;
          brk_pend <= 1'b0;
        end else if (hold_full) begin
          st    <= S_SHIFT;
          shreg <= frame;
          len_q <= frame_len;
        end else begin
          st <= S_IDLE;
        end
      end else if (tick) begin
        case (st)
          S_SHIFT: begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            cnt   <= cnt_nx[CNT_W-1:0];
          end
          S_BREAK: begin
            if (brk_exit) begin
              st  <= S_GAP;
              cnt <= '0;
            end else if (cnt != '1) begin
              cnt <= cnt_nx[CNT_W-1:0];
            end
          end
          S_GAP:   cnt <= cnt_nx[CNT_W-1:0];
          default: cnt <= '0;
        endcase
      end
      if (start_acc) brk_pend <= 1'b1;
      if (stop_acc)  stop_req <= 1'b1;
      if (brk_exit)  stop_req <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_brk_tx.sv
`timescale 1ns/1ps
module uart_brk_tx #(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8,
  parameter int MIN_GAP = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic [1:0]         cfg_nbits,
  input  logic               cfg_par_en,
  input  logic               cfg_par_odd,
  input  logic [GUARD_W-1:0] cfg_guard,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               brk_start,
  input  logic               brk_stop,
  output logic               txd,
  output logic               tx_rdy,
  output logic               tx_empty
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int CNT_W   = GUARD_W;

  logic               hold_full, take, start_acc, wr_en;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len, len_q;
  logic [CNT_W-1:0]   gap_len;
  logic               brk_pend, brk_on, gap_on, idle;

  assign tx_rdy    = !hold_full && !brk_on && !gap_on;
  assign in_ready  = tx_rdy;
  assign tx_empty  = !hold_full && idle && !brk_pend;
  assign start_acc = brk_start && tx_rdy && !brk_pend;
  assign wr_en     = in_valid && in_ready && !brk_pend;
  assign gap_len   = (cfg_guard > CNT_W'(MIN_GAP)) ? cfg_guard : CNT_W'(MIN_GAP);

  utx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(in_data),
    .pop(take), .full(hold_full), .data(hold_data)
  );

  utx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_framer (
    .data(hold_data), .nbits_code(cfg_nbits), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .frame(frame), .frame_len(frame_len)
  );

  utx_engine #(.FRAME_W(FRAME_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .hold_full(hold_full),
    .frame(frame), .frame_len(frame_len), .gap_len(gap_len),
    .start_acc(start_acc), .start_raw(brk_start), .stop_raw(brk_stop),
    .take(take), .txd(txd), .brk_pend(brk_pend), .brk_on(brk_on),
    .gap_on(gap_on), .idle(idle), .len_q(len_q)
  );
endmodule

// File: rtl/utx_chk.sv
`timescale 1ns/1ps
module utx_chk #(
  parameter int LEN_W = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             baud_tick,
  input logic             txd,
  input logic             tx_rdy,
  input logic             tx_empty,
  input logic             in_valid,
  input logic             in_ready,
  input logic             brk_on,
  input logic             gap_on,
  input logic             brk_pend,
  input logic             hold_full,
  input logic [LEN_W-1:0] len_q,
  input logic [CNT_W-1:0] gap_len
);
  logic [CNT_W-1:0] bcnt, gcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !brk_on) bcnt <= '0;
    else if (baud_tick && bcnt != '1) bcnt <= bcnt + 1'b1;
    if (!rst_n || !gap_on) gcnt <= '0;
    else if (baud_tick && gcnt != '1) gcnt <= gcnt + 1'b1;
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);
  p_ready_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == tx_rdy);
  p_brk_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_on) |-> (bcnt >= {{(CNT_W - LEN_W){1'b0}}, len_q}));
  p_gap_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gap_on) |-> (gcnt >= gap_len));
  p_gap_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gap_on |-> txd);
  p_discard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pend && in_valid && in_ready) |=> !hold_full);
  p_flags_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_on || gap_on) |-> (!tx_rdy && !tx_empty));
endmodule

bind uart_brk_tx utx_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .txd(txd),
  .tx_rdy(tx_rdy), .tx_empty(tx_empty), .in_valid(in_valid),
  .in_ready(in_ready), .brk_on(brk_on), .gap_on(gap_on),
  .brk_pend(brk_pend), .hold_full(hold_full), .len_q(len_q),
  .gap_len(gap_len)
);

// File: tb/uart_brk_tx_bench.sv
`timescale 1ns/1ps
module uart_brk_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div = '0;
  logic       baud_tick;
  logic [1:0] cfg_nbits = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [7:0] cfg_guard = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       brk_start = 1'b0, brk_stop = 1'b0;
  logic       in_ready, txd, tx_rdy, tx_empty;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) div <= '0;
    else        div <= div + 2'd1;
  end
  assign baud_tick = rst_n && (div == 2'd3);

  uart_brk_tx u_uart_brk_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_nbits(cfg_nbits),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_guard(cfg_guard),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .brk_start(brk_start), .brk_stop(brk_stop), .txd(txd),
    .tx_rdy(tx_rdy), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // value of txd during the bit period that ends at the next baud tick
  task automatic next_bit(output logic b);
    do @(negedge clk); while (!baud_tick);
    b = txd;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); brk_start = 1'b1;
    @(negedge clk); brk_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); brk_stop = 1'b1;
    @(negedge clk); brk_stop = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    logic b;
    for (int i = 0; i < n; i++) next_bit(b);
  endtask

  // skipped highs, then length of low run, then high run (capped)
  task automatic measure(output int sk, output int lo, output int hi, input int cap);
    logic b;
    sk = 0; lo = 0; hi = 0; b = 1'b1;
    while (b && sk < 200) begin next_bit(b); if (b) sk++; end
    while (!b && lo < 400) begin lo++; next_bit(b); end
    hi = 1;
    while (hi < cap) begin
      next_bit(b);
      if (!b) break;
      hi++;
    end
  endtask

  task automatic decode(output logic [10:0] bits, input int n);
    logic b;
    int   w;
    bits = '1; w = 0; b = 1'b1;
    while (b && w < 100) begin next_bit(b); w++; end
    bits[0] = b;
    for (int i = 1; i < n; i++) begin next_bit(b); bits[i] = b; end
  endtask

  function automatic logic [10:0] expect_frame(input logic [7:0] d, input int nb,
                                               input bit pe, input bit po);
    logic [10:0] f;
    logic p;
    f = '1; f[0] = 1'b0; p = po;
    for (int i = 0; i < nb; i++) begin f[1 + i] = d[i]; p = p ^ d[i]; end
    if (pe) f[1 + nb] = p;
    return f;
  endfunction

  task automatic wait_empty();
    int w;
    w = 0;
    while (!tx_empty && w < 2000) begin @(negedge clk); w++; end
  endtask

  initial begin
    #1_900_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int sk, lo, hi;
    logic [10:0] got, expv;
    logic b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    chk(tx_rdy == 1'b1, "R1 tx_rdy", int'(tx_rdy), 1);
    chk(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R2 / R3: framing sweep over every length, parity mode and data value
    for (int pm = 0; pm < 3; pm++) begin
      for (int code = 0; code < 4; code++) begin
        int nb, n;
        nb = 5 + code;
        cfg_nbits   = 2'(code);
        cfg_par_en  = (pm != 0);
        cfg_par_odd = (pm == 2);
        n = nb + 2 + ((pm != 0) ? 1 : 0);
        for (int d = 0; d < (1 << nb); d++) begin
          chk(in_ready == tx_rdy, "R3 ready equals tx_rdy", int'(in_ready), int'(tx_rdy));
          fork
            push(8'(d));
            decode(got, n);
          join
          expv = expect_frame(8'(d), nb, pm != 0, pm == 2);
          for (int i = n; i < 11; i++) begin got[i] = 1'b1; expv[i] = 1'b1; end
          chk(got == expv, "R2 frame bits", int'(got), int'(expv));
        end
      end
    end
    wait_empty();
    chk(tx_empty && txd, "R1 idle after sweep", int'(tx_empty), 1);

    // Scenario A: 8N1, guard 0, break from idle with early stop, then a data word
    cfg_nbits = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_guard = 8'd0;
    fork
      measure(sk, lo, hi, 60);
      begin
        pulse_start();
        pulse_stop();
        while (tx_rdy) @(negedge clk);
        chk(!tx_rdy && !tx_empty, "R12 flags low in break", int'(tx_empty), 0);
        push(8'h00);
      end
    join
    chk(lo == 10, "R5 minimum break length", lo, 10);
    chk(hi >= 12 && hi <= 13, "R10 gap of 12", hi, 12);
    wait_empty();
    chk(tx_rdy && tx_empty, "R12 flags back after gap", int'(tx_rdy), 1);

    // Scenario B: break requested mid-character; word pushed while pending
    fork
      begin
        decode(got, 10);
        expv = expect_frame(8'hA5, 8, 1'b0, 1'b0);
        got[10] = 1'b1; expv[10] = 1'b1;
        chk(got == expv, "R4 character completes", int'(got), int'(expv));
        measure(sk, lo, hi, 60);
        chk(sk == 0, "R4 break follows stop bit", sk, 0);
        chk(lo == 10, "R5 break with deferred stop", lo, 10);
        chk(hi == 60, "R11 pending word discarded", hi, 60);
      end
      begin
        push(8'hA5);
        while (!in_ready) @(negedge clk);
        pulse_start();
        chk(in_ready == 1'b1, "R11 ready while pending", int'(in_ready), 1);
        chk(tx_empty == 1'b0, "R12 empty low while pending", int'(tx_empty), 0);
        push(8'h3C);
        wait_ticks(3);
        pulse_stop();
      end
    join
    wait_empty();

    // Scenario C: lone stop, simultaneous start+stop, repeated start, late stop
    pulse_stop();
    b = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic s;
      next_bit(s);
      b = b & s;
    end
    chk(b == 1'b1, "R8 lone stop ignored", int'(b), 1);
    chk(tx_empty == 1'b1, "R8 still empty", int'(tx_empty), 1);
    fork
      measure(sk, lo, hi, 60);
      begin
        @(negedge clk); brk_start = 1'b1; brk_stop = 1'b1;
        @(negedge clk); brk_start = 1'b0; brk_stop = 1'b0;
        wait_ticks(25);
        chk(!tx_rdy && !tx_empty, "R12 flags low in long break", int'(tx_rdy), 0);
        pulse_start();
        wait_ticks(3);
        pulse_stop();
      end
    join
    chk(lo >= 25, "R9 simultaneous stop ignored", lo, 25);
    chk(lo >= 28 && lo <= 31, "R6 late stop ends break", lo, 29);
    chk(hi == 60, "R7 repeated start ignored", hi, 60);
    wait_empty();
    chk(tx_rdy && tx_empty, "R12 flags after long break", int'(tx_empty), 1);

    // Scenario D: 5 data bits even parity, guard 20
    cfg_nbits = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_guard = 8'd20;
    fork
      measure(sk, lo, hi, 60);
      begin
        pulse_start();
        pulse_stop();
        while (tx_rdy) @(negedge clk);
        push(8'h15);
      end
    join
    chk(lo == 8, "R5 minimum for short frame", lo, 8);
    chk(hi >= 20 && hi <= 21, "R10 guard longer than 12", hi, 20);
    wait_empty();
    chk(txd == 1'b1, "R1 idle at end", int'(txd), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule